// File: doc/BRIEF.md
# Configurable timer counter channel

This block is one channel of a general-purpose timer. It holds a 16-bit counter that advances on a selected count source and two general registers, A and B. Each general register can either compare against the counter, giving a one-cycle match strobe, or capture the counter value on a rising edge of its capture pin. A 7-bit control field picks the count source, the external clock edge to count and the event that returns the counter to zero.

The count source can be one of four prescaled internal clocks, which are already synchronous to the system clock and count on falling edges only, or one of four external pins. External pins pass through a synchronizer and are counted on the rising edge, the falling edge or both edges. A phase-counting input overrides every clock setting. The counter then moves up or down from a quadrature pair. Channels in a group share clears. A channel whose clear comes from its own general register drives `sync_clr_out`. A channel set to group clear resets whenever its `sync_clr_in` is high.

Software reaches five write locations through a 3-bit address: control (0), mode and overflow (1), counter (2), general register A (3) and general register B (4).

Top module: `tmr_chan`

## Requirements
- R1: After reset the counter, the control readback, the overflow flag, both match strobes and `sync_clr_out` are all 0.
- R2: Address 0 writes `wr_data[6:0]` into the control field, which reads back on `ctrl_rd[6:0]`. `ctrl_rd[7]` always reads 0, and writing bit 7 has no effect on counting.
- R3: With control bit 2 = 0, the counter advances by one on each falling edge of `int_clk[ctrl[1:0]]`. Rising edges, unselected internal inputs and the edge-select bits [4:3] have no effect.
- R4: With control bit 2 = 1 and edge select [4:3] = 00, each rising edge of `ext_clk[ctrl[1:0]]` advances the counter by one.
- R5: With edge select 01 and an external source, only falling edges of the selected pin advance the counter.
- R6: With edge select 10 or 11 and an external source, both edges of the selected pin advance the counter.
- R7: While `phase_en` is 1, the clock source and edge fields are ignored. Each edge of `ph_a` or `ph_b` adds one when A leads B (sequence 00, 10, 11, 01) and subtracts one when B leads A.
- R8: A general register in compare mode (mode bit 0 for A, bit 1 for B, 0 = compare) pulses its `cmp_` output for one cycle when a count step occurs while the counter equals the register. With clear select [6:5] = 00 the counter keeps running past the match.
- R9: With clear select 01, an A event (a compare match, or a capture in capture mode) loads 0 instead of the next count, and `sync_clr_out` is high in that cycle.
- R10: With clear select 10 and general register B in capture mode (mode bit 1 = 1), a rising edge on `cap_b_pin` copies the counter into B, clears the counter and raises `sync_clr_out`.
- R11: With clear select 11, a high `sync_clr_in` clears the counter at the next edge. With any other clear select, `sync_clr_in` is ignored.
- R12: An up step from 0xFFFF to 0x0000 sets `ovf`, which stays set until address 1 is written with bit 2 = 0. Writing bit 2 = 1 leaves it set.
- R13: When a clear and a count step fall in the same cycle, the counter becomes 0 and `ovf` is not set.
- R14: A general register in capture mode loads the counter value on each synchronized rising edge of its capture pin. The counter is left unchanged when clear select is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write location: 0 control, 1 mode, 2 counter, 3 GR A, 4 GR B |
| wr_data | input | 16 | Write data |
| phase_en | input | 1 | Phase-counting mode select |
| int_clk | input | 4 | Prescaled internal clocks, synchronous to clk |
| ext_clk | input | 4 | Asynchronous external clock pins |
| cap_a_pin | input | 1 | Capture trigger for general register A |
| cap_b_pin | input | 1 | Capture trigger for general register B |
| ph_a | input | 1 | Quadrature phase A |
| ph_b | input | 1 | Quadrature phase B |
| sync_clr_in | input | 1 | Clear request from the synchronized group |
| sync_clr_out | output | 1 | This channel clears from its own general register this cycle |
| count | output | 16 | Counter value |
| cmp_a | output | 1 | Compare-match strobe, register A |
| cmp_b | output | 1 | Compare-match strobe, register B |
| gr_a | output | 16 | General register A (holds the captured value) |
| gr_b | output | 16 | General register B (holds the captured value) |
| ovf | output | 1 | Sticky overflow flag |
| ctrl_rd | output | 8 | Control readback, bit 7 reads 0 |

## Verification
The hardest situations to reach from the ports are the wrap from 0xFFFF and the same-cycle collision of a clear with a count step. Reaching either by counting alone would take tens of thousands of pulses. The stimulus first writes the counter to a value just below the point of interest. For the collision it also sets general register A to 0xFFFF with clear-on-A selected, so the next external edge produces a step and a match in the same cycle. Phase-counting direction is checked by stepping through both quadrature orders starting from a preset midrange value, so a decrement cannot be mistaken for a wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int N_SRC     = 4;   // sources per class (internal / external)
    localparam int SRC_IDX_W = 2;
    localparam int AW        = 3;

    typedef enum logic [1:0] {
        CLR_NONE  = 2'b00,
        CLR_GRA   = 2'b01,
        CLR_GRB   = 2'b10,
        CLR_GROUP = 2'b11
    } clr_sel_e;

    // Field order matches control bits [6:0].
    typedef struct packed {
        clr_sel_e               clr;
        logic [1:0]             edge_sel;
        logic                   ext_src;
        logic [SRC_IDX_W-1:0]   src_idx;
    } ctrl_t;

    localparam logic [AW-1:0] ADDR_CTRL = 3'd0;
    localparam logic [AW-1:0] ADDR_MODE = 3'd1;
    localparam logic [AW-1:0] ADDR_CNT  = 3'd2;
    localparam logic [AW-1:0] ADDR_GRA  = 3'd3;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/tmr_step.sv
module tmr_step
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic             phase_en,
    input  logic [N_SRC-1:0] int_clk,
    input  logic [N_SRC-1:0] ext_s,
    input  logic             ph_a_s,
    input  logic             ph_b_s,
    output logic             step_up,
    output logic             step_dn
);
    typedef struct packed {
        logic [N_SRC-1:0] int_q;
        logic [N_SRC-1:0] int_p;
        logic [N_SRC-1:0] ext_p;
        logic             pa_p;
        logic             pb_p;
    } st_t;

    st_t st_d, st_q;
    logic [N_SRC-1:0] int_fall, ext_rise, ext_fall, ext_ev;
    logic clk_ev, a_chg, b_chg, ph_up, ph_dn;

    always_comb begin
        st_d       = st_q;
        st_d.int_q = int_clk;
        st_d.int_p = st_q.int_q;
        st_d.ext_p = ext_s;
        st_d.pa_p  = ph_a_s;
        st_d.pb_p  = ph_b_s;

        // internal clocks: falling edges only, edge select has no say
        int_fall = st_q.int_p & ~st_q.int_q;
        ext_rise = ext_s & ~st_q.ext_p;
        ext_fall = ~ext_s & st_q.ext_p;
        case (ctrl.edge_sel)
            2'b00:   ext_ev = ext_rise;
            2'b01:   ext_ev = ext_fall;
            default: ext_ev = ext_rise | ext_fall;
        endcase
        clk_ev = ctrl.ext_src ? ext_ev[ctrl.src_idx] : int_fall[ctrl.src_idx];

        // quadrature: a change of A counts up when A now differs from B,
        // a change of B counts up when B now equals A
        a_chg = ph_a_s ^ st_q.pa_p;
        b_chg = ph_b_s ^ st_q.pb_p;
        ph_up = (a_chg & ~b_chg & (ph_a_s ^ ph_b_s)) |
                (b_chg & ~a_chg & ~(ph_a_s ^ ph_b_s));
        ph_dn = (a_chg & ~b_chg & ~(ph_a_s ^ ph_b_s)) |
                (b_chg & ~a_chg & (ph_a_s ^ ph_b_s));

        step_up = phase_en ? ph_up : clk_ev;
        step_dn = phase_en & ph_dn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: in phase mode, a quiet phase pair produces no step whatever the clocks do
    p_phase_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en && ph_a_s == st_q.pa_p && ph_b_s == st_q.pb_p) |-> (!step_up && !step_dn));

    // R7: never both directions at once
    p_step_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn));
endmodule

// File: rtl/tmr_gr.sv
module tmr_gr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_cap,
    input  logic          cap_s,
    input  logic [CW-1:0] cnt,
    input  logic          step,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] gr,
    output logic          evt,
    output logic          match
);
    typedef struct packed {
        logic [CW-1:0] gr;
        logic          cap_p;
    } st_t;

    st_t  st_d, st_q;
    logic cap_rise;

    always_comb begin
        st_d       = st_q;
        st_d.cap_p = cap_s;
        cap_rise   = is_cap & cap_s & ~st_q.cap_p;
        match      = ~is_cap & step & (cnt == st_q.gr);
        evt        = match | cap_rise;
        if (cap_rise)   st_d.gr = cnt;      // capture beats a bus write
        else if (wr_en) st_d.gr = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{gr: '1, cap_p: 1'b0};
        else        st_q <= st_d;
    end

    assign gr = st_q.gr;

    // R14: a capture edge stores the counter value seen in that cycle
    p_capture_r14: assert property (@(posedge clk) disable iff (!rst_n)
        cap_rise |=> (gr == $past(cnt)));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CW-1:0]    wr_data,
    input  logic             phase_en,
    input  logic [N_SRC-1:0] int_clk,
    input  logic [N_SRC-1:0] ext_clk,
    input  logic             cap_a_pin,
    input  logic             cap_b_pin,
    input  logic             ph_a,
    input  logic             ph_b,
    input  logic             sync_clr_in,
    output logic             sync_clr_out,
    output logic [CW-1:0]    count,
    output logic             cmp_a,
    output logic             cmp_b,
    output logic [CW-1:0]    gr_a,
    output logic [CW-1:0]    gr_b,
    output logic             ovf,
    output logic [7:0]       ctrl_rd
);
    localparam int            SW      = N_SRC + 4;
    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        ctrl_t         ctrl;
        logic [1:0]    cap_mode;   // bit0: A captures, bit1: B captures
        logic          ovf;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    logic [SW-1:0]    pins_s;
    logic             step_up, step_dn;
    logic [1:0]       gr_evt, gr_match;
    logic [1:0][CW-1:0] gr_val;
    logic             cnt_wr, own_clr, clr;

    tmr_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ph_b, ph_a, cap_b_pin, cap_a_pin, ext_clk}),
        .dout (pins_s)
    );

    tmr_step u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl    (st_q.ctrl),
        .phase_en(phase_en),
        .int_clk (int_clk),
        .ext_s   (pins_s[N_SRC-1:0]),
        .ph_a_s  (pins_s[N_SRC+2]),
        .ph_b_s  (pins_s[N_SRC+3]),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    for (genvar g = 0; g < 2; g++) begin : g_gr
        localparam logic [AW-1:0] GR_ADDR = AW'(ADDR_GRA + g);
        tmr_gr #(.CW(CW)) u_gr (
            .clk    (clk),
            .rst_n  (rst_n),
            .is_cap (st_q.cap_mode[g]),
            .cap_s  (pins_s[N_SRC+g]),
            .cnt    (st_q.cnt),
            .step   (step_up | step_dn),
            .wr_en  (wr_en && wr_addr == GR_ADDR),
            .wr_data(wr_data),
            .gr     (gr_val[g]),
            .evt    (gr_evt[g]),
            .match  (gr_match[g])
        );
    end

    always_comb begin
        st_d   = st_q;
        cnt_wr = wr_en && wr_addr == ADDR_CNT;

        if (wr_en && wr_addr == ADDR_CTRL) st_d.ctrl = ctrl_t'(wr_data[6:0]);
        if (wr_en && wr_addr == ADDR_MODE) begin
            st_d.cap_mode = wr_data[1:0];
            st_d.ovf      = st_q.ovf & wr_data[2];
        end

        own_clr = (st_q.ctrl.clr == CLR_GRA && gr_evt[0]) ||
                  (st_q.ctrl.clr == CLR_GRB && gr_evt[1]);
        clr     = own_clr || (st_q.ctrl.clr == CLR_GROUP && sync_clr_in);

        if (cnt_wr) begin
            st_d.cnt = wr_data;
        end else if (clr) begin
            st_d.cnt = '0;
        end else if (step_up) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_MAX) st_d.ovf = 1'b1;
        end else if (step_dn) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ctrl: '{clr: CLR_NONE, default: '0}, default: '0};
        else        st_q <= st_d;
    end

    assign sync_clr_out = own_clr;
    assign count        = st_q.cnt;
    assign cmp_a        = gr_match[0];
    assign cmp_b        = gr_match[1];
    assign gr_a         = gr_val[0];
    assign gr_b         = gr_val[1];
    assign ovf          = st_q.ovf;
    assign ctrl_rd      = {1'b0, st_q.ctrl};

    // R12: the flag only rises out of an all-ones counter
    p_ovf_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(count) == CNT_MAX));

    // R12: the flag holds unless software writes a zero to it
    p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(wr_en && wr_addr == ADDR_MODE && !wr_data[2])) |=> ovf);

    // R9 / R13: an own-register clear lands as zero, whatever step came with it
    p_own_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_clr_out && !cnt_wr) |=> (count == '0 && $stable(ovf)));

    // R11: a group clear request in group mode empties the counter
    p_group_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[6:5] == 2'b11 && sync_clr_in && !cnt_wr) |=> (count == '0));
endmodule

// File: tb/tb_tmr_chan.sv
module tb_tmr_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        phase_en = 1'b0;
    logic [3:0]  int_clk = '0;
    logic [3:0]  ext_clk = '0;
    logic        cap_a_pin = 1'b0, cap_b_pin = 1'b0;
    logic        ph_a = 1'b0, ph_b = 1'b0;
    logic        sync_clr_in = 1'b0;
    logic        sync_clr_out, cmp_a, cmp_b, ovf;
    logic [15:0] count, gr_a, gr_b;
    logic [7:0]  ctrl_rd;

    int errors = 0, checks = 0;
    int hits_a = 0, hits_sync = 0;

    always #10 clk = ~clk;   // 50 MHz

    tmr_chan dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .phase_en(phase_en), .int_clk(int_clk), .ext_clk(ext_clk),
        .cap_a_pin(cap_a_pin), .cap_b_pin(cap_b_pin), .ph_a(ph_a), .ph_b(ph_b),
        .sync_clr_in(sync_clr_in), .sync_clr_out(sync_clr_out), .count(count),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .gr_a(gr_a), .gr_b(gr_b), .ovf(ovf), .ctrl_rd(ctrl_rd)
    );

    always @(negedge clk) begin
        if (cmp_a)        hits_a++;
        if (sync_clr_out) hits_sync++;
    end

    // src: 0 internal, 1 external, 2 phase A-leads, 3 phase B-leads
    typedef struct packed {
        logic [7:0]  ctrl;
        logic        ph;
        logic [1:0]  src;
        logic [1:0]  idx;
        logic [7:0]  n;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{8'h00, 1'b0, 2'd0, 2'd0, 8'd5, 16'h0105},  // R3 internal 0
        '{8'h19, 1'b0, 2'd0, 2'd1, 8'd4, 16'h0104},  // R3 edge select ignored
        '{8'h03, 1'b0, 2'd0, 2'd2, 8'd3, 16'h0100},  // R3 unselected input
        '{8'h04, 1'b0, 2'd1, 2'd0, 8'd6, 16'h0106},  // R4 rising
        '{8'h0D, 1'b0, 2'd1, 2'd1, 8'd5, 16'h0105},  // R5 falling
        '{8'h16, 1'b0, 2'd1, 2'd2, 8'd5, 16'h010A},  // R6 both (10)
        '{8'h1F, 1'b0, 2'd1, 2'd3, 8'd3, 16'h0106},  // R6 both (11)
        '{8'h04, 1'b1, 2'd2, 2'd0, 8'd3, 16'h010C},  // R7 up
        '{8'h00, 1'b1, 2'd3, 2'd0, 8'd3, 16'h00F4},  // R7 down
        '{8'h04, 1'b1, 2'd1, 2'd0, 8'd4, 16'h0100},  // R7 clock ignored
        '{8'h84, 1'b0, 2'd1, 2'd0, 8'd2, 16'h0102}   // R2 bit 7 ignored
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [1:0] src, input logic [1:0] idx);
        case (src)
            2'd0: begin int_clk[idx] = 1'b1; gap(4); int_clk[idx] = 1'b0; gap(4); end
            2'd1: begin ext_clk[idx] = 1'b1; gap(4); ext_clk[idx] = 1'b0; gap(4); end
            2'd2: begin ph_a = 1'b1; gap(4); ph_b = 1'b1; gap(4);
                        ph_a = 1'b0; gap(4); ph_b = 1'b0; gap(4); end
            default: begin ph_b = 1'b1; gap(4); ph_a = 1'b1; gap(4);
                        ph_b = 1'b0; gap(4); ph_a = 1'b0; gap(4); end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        gap(3);
        rst_n = 1'b1;
        gap(2);
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 ctrl", ctrl_rd, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 strobes", {cmp_a, cmp_b, sync_clr_out}, 0);

        // table of counting modes
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, {8'h00, VEC[i].ctrl});
            phase_en = VEC[i].ph;
            gap(4);
            wr(3'd2, 16'h0100);
            for (int k = 0; k < int'(VEC[i].n); k++) pulse(VEC[i].src, VEC[i].idx);
            gap(8);
            chk($sformatf("R3-R7 table vector %0d count", i), count, VEC[i].exp);
            chk($sformatf("R2 table vector %0d ctrl readback", i), ctrl_rd, {1'b0, VEC[i].ctrl[6:0]});
        end
        phase_en = 1'b0;

        // R8 compare without clear
        wr(3'd0, 16'h0004); wr(3'd1, 16'h0000); wr(3'd3, 16'h0003); wr(3'd2, 16'h0000);
        gap(2); hits_a = 0; hits_sync = 0;
        for (int k = 0; k < 6; k++) pulse(2'd1, 2'd0);
        gap(8);
        chk("R8 count runs on", count, 6);
        chk("R8 one match strobe", hits_a, 1);
        chk("R8 no sync out", hits_sync, 0);

        // R9 clear on A compare
        wr(3'd0, 16'h0024); wr(3'd2, 16'h0000);
        gap(2); hits_a = 0; hits_sync = 0;
        for (int k = 0; k < 6; k++) pulse(2'd1, 2'd0);
        gap(8);
        chk("R9 count after clear", count, 2);
        chk("R9 sync out once", hits_sync, 1);

        // R14 capture without clear
        wr(3'd0, 16'h0004); wr(3'd1, 16'h0001); wr(3'd2, 16'h0033);
        cap_a_pin = 1'b1; gap(8);
        chk("R14 captured value", gr_a, 16'h0033);
        chk("R14 counter untouched", count, 16'h0033);
        cap_a_pin = 1'b0; gap(4);

        // R10 clear on B capture
        wr(3'd0, 16'h0044); wr(3'd1, 16'h0002); wr(3'd2, 16'h0050);
        gap(2); hits_sync = 0;
        cap_b_pin = 1'b1; gap(8);
        chk("R10 captured value", gr_b, 16'h0050);
        chk("R10 counter cleared", count, 0);
        chk("R10 sync out once", hits_sync, 1);
        cap_b_pin = 1'b0; gap(4);

        // R11 group clear
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0064); wr(3'd2, 16'h0020);
        sync_clr_in = 1'b1; gap(1); sync_clr_in = 1'b0; gap(2);
        chk("R11 group clear", count, 0);
        wr(3'd0, 16'h0004); wr(3'd2, 16'h0020);
        sync_clr_in = 1'b1; gap(1); sync_clr_in = 1'b0; gap(2);
        chk("R11 ignored when not selected", count, 16'h0020);

        // R12 overflow
        wr(3'd2, 16'hFFFE);
        pulse(2'd1, 2'd0); pulse(2'd1, 2'd0); gap(6);
        chk("R12 wrap value", count, 0);
        chk("R12 flag set", ovf, 1);
        pulse(2'd1, 2'd0); gap(6);
        chk("R12 flag sticky", ovf, 1);
        wr(3'd1, 16'h0004); gap(1);
        chk("R12 write one keeps", ovf, 1);
        wr(3'd1, 16'h0000); gap(1);
        chk("R12 write zero clears", ovf, 0);

        // R13 clear beats step at the wrap point
        wr(3'd0, 16'h0024); wr(3'd3, 16'hFFFF); wr(3'd2, 16'hFFFF);
        pulse(2'd1, 2'd0); gap(6);
        chk("R13 clear wins", count, 0);
        chk("R13 no overflow", ovf, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule